// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Front End

This block is the software-visible register file of a multi-channel DMA controller. It sits on a simple 32-bit read/write bus and decodes a 4 KB window. The window holds a five-register bank for each channel (source address, destination address, linked-list pointer, control and configuration), a global configuration word, the raw terminal-count and error interrupt bits, the interrupt status views, a summary of the enabled channels, and a run of identification bytes near the top of the window.

The transfer engine, which is outside this block, reads the channel registers and the global configuration. It reports completions and failures through single-cycle set pulses, one bit per channel. The interrupt mask for each channel is not a separate register. It comes from two bits in that channel's own configuration word. The block drives three level interrupt outputs: terminal count, error, and their OR. Reads are combinational from the address. Writes take effect on the rising clock edge while select and write are both high.

Top module: `dma_regfile`

## Requirements
- R1: A channel register sits at byte offset 0x100 + 32*c + 4*r. Here c is the channel index and r picks the register: 0 source, 1 destination, 2 link pointer, 3 control, 4 configuration. Each register stores and returns all 32 bits. Register slots 5 to 7 read zero and ignore writes.
- R2: When the channel index is at or above NCHAN, the access is ignored and the read returns zero. NCHAN is 8 or 2.
- R3: Word index 12 (offset 0x030) is the global configuration. Its bits [2:0] are stored: bit 0 is the controller enable and bits 1 and 2 are the master endianness controls. Its upper bits read zero.
- R4: A tc_set or err_set pulse on bit c sets raw bit c. The raw terminal-count bits read at offset 0x014 and the raw error bits at offset 0x018, with bit c standing for channel c.
- R5: Writing offset 0x008 clears each raw terminal-count bit that is 1 in the written data. Writing offset 0x010 does the same for the raw error bits.
- R6: When a set pulse and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R7: Configuration bit 15 of channel c is its terminal-count mask and bit 14 is its error mask. Offset 0x004 reads the masked terminal-count bits, 0x00C reads the masked error bits, and 0x000 reads the OR of the two.
- R8: irq_tc is high when any masked terminal-count bit is set. irq_err is high when any masked error bit is set. irq_any is high when either of them is high.
- R9: Offset 0x01C returns a bitmap in which bit c equals bit 0 of channel c's configuration.
- R10: Offsets 0xFE0 to 0xFFC return one identification byte per word, in bits [7:0]. The bytes in order are 0x80 (0x81 when NCHAN is 2), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of any other offset return zero. Writes to any other offset change no state.
- R12: Reset clears every channel register, every raw interrupt bit and the global configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | High for a write, low for a read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tc_set | input | NCHAN | Terminal-count set pulses, one per channel |
| err_set | input | NCHAN | Error set pulses, one per channel |
| irq_any | output | 1 | OR of both interrupt outputs |
| irq_err | output | 1 | Masked error interrupt |
| irq_tc | output | 1 | Masked terminal-count interrupt |

## Verification
The bound checker checks a set of relations on every cycle:
- a set pulse always leaves its raw bit high, including when a clear arrives in the same cycle;
- a clear write drops every targeted bit that is not being set at the same time;
- no raw bit rises without a pulse;
- an interrupt output is never high while its raw vector is empty;
- the state is zero after reset.

Other behaviour shows only in the bench's scenarios, because it needs the bus read path:
- the address decode of the channel banks;
- out-of-range channels, both in the default build and in a two-channel build;
- the mask bits taken from the configuration words;
- the enabled-channel map;
- the identification bytes;
- the silence of undefined offsets.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int SLOT_MAX  = 8;
    localparam int GCFG_W    = 3;

    // global word indices
    localparam logic [5:0] GW_STAT    = 6'd0;
    localparam logic [5:0] GW_TCSTAT  = 6'd1;
    localparam logic [5:0] GW_TCCLR   = 6'd2;
    localparam logic [5:0] GW_ERRSTAT = 6'd3;
    localparam logic [5:0] GW_ERRCLR  = 6'd4;
    localparam logic [5:0] GW_TCRAW   = 6'd5;
    localparam logic [5:0] GW_ERRRAW  = 6'd6;
    localparam logic [5:0] GW_ENMAP   = 6'd7;
    localparam logic [5:0] GW_GCFG    = 6'd12;

    // configuration bit positions
    localparam int CFG_EN_BIT      = 0;
    localparam int CFG_ERRMASK_BIT = 14;
    localparam int CFG_TCMASK_BIT  = 15;

    typedef enum logic [2:0] {
        SEL_SRC  = 3'd0,
        SEL_DST  = 3'd1,
        SEL_LINK = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_CFG  = 3'd4
    } chreg_e;

    typedef enum logic [1:0] {
        RGN_GLOBAL,
        RGN_CHAN,
        RGN_ID,
        RGN_NONE
    } region_e;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] link;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] cfg;
    } chan_regs_t;

    function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
        if (a[11:8] == 4'h0)       return RGN_GLOBAL;
        else if (a[11:8] == 4'h1)  return RGN_CHAN;
        else if (a[11:5] == 7'h7F) return RGN_ID;
        else                       return RGN_NONE;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input logic two_chan);
        case (idx)
            3'd0:    return two_chan ? 8'h81 : 8'h80;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h0A;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
    import dmareg_pkg::*;
#(
    parameter int NCHAN = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [2:0]                    ch_idx,
    input  logic [2:0]                    reg_sel,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NCHAN-1:0]              en_map,
    output logic [NCHAN-1:0]              tc_mask,
    output logic [NCHAN-1:0]              err_mask,
    output chan_regs_t [NCHAN-1:0]        regs
);

    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        chan_regs_t r;
        logic       hit;

        assign hit = wr_en && (ch_idx == 3'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (hit) begin
                case (reg_sel)
                    SEL_SRC:  r.src  <= wdata;
                    SEL_DST:  r.dst  <= wdata;
                    SEL_LINK: r.link <= wdata;
                    SEL_CTRL: r.ctrl <= wdata;
                    SEL_CFG:  r.cfg  <= wdata;
                    default:  ;
                endcase
            end
        end

        assign regs[g]     = r;
        assign en_map[g]   = r.cfg[CFG_EN_BIT];
        assign tc_mask[g]  = r.cfg[CFG_TCMASK_BIT];
        assign err_mask[g] = r.cfg[CFG_ERRMASK_BIT];
    end

    always_comb begin
        chan_regs_t pick;
        logic       found;
        pick  = '0;
        found = 1'b0;
        for (int c = 0; c < NCHAN; c++) begin
            if (ch_idx == 3'(c)) begin
                pick  = regs[c];
                found = 1'b1;
            end
        end
        rdata = '0;
        if (found) begin
            case (reg_sel)
                SEL_SRC:  rdata = pick.src;
                SEL_DST:  rdata = pick.dst;
                SEL_LINK: rdata = pick.link;
                SEL_CTRL: rdata = pick.ctrl;
                SEL_CFG:  rdata = pick.cfg;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dmareg_pkg::*;
#(
    parameter int NCHAN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCHAN-1:0] tc_set,
    input  logic [NCHAN-1:0] err_set,
    input  logic             tc_clr_we,
    input  logic             err_clr_we,
    input  logic [NCHAN-1:0] clr_bits,
    input  logic [NCHAN-1:0] tc_mask,
    input  logic [NCHAN-1:0] err_mask,
    output logic [NCHAN-1:0] tc_raw,
    output logic [NCHAN-1:0] err_raw,
    output logic [NCHAN-1:0] tc_masked,
    output logic [NCHAN-1:0] err_masked,
    output logic             irq_tc,
    output logic             irq_err,
    output logic             irq_any
);

    logic [NCHAN-1:0] tc_clr, err_clr;

    assign tc_clr  = tc_clr_we  ? clr_bits : '0;
    assign err_clr = err_clr_we ? clr_bits : '0;

    // set pulses win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            tc_raw  <= '0;
            err_raw <= '0;
        end else begin
            tc_raw  <= (tc_raw  & ~tc_clr)  | tc_set;
            err_raw <= (err_raw & ~err_clr) | err_set;
        end
    end

    assign tc_masked  = tc_raw  & tc_mask;
    assign err_masked = err_raw & err_mask;
    assign irq_tc     = |tc_masked;
    assign irq_err    = |err_masked;
    assign irq_any    = irq_tc | irq_err;

endmodule

// File: rtl/dma_global_regs.sv
module dma_global_regs
    import dmareg_pkg::*;
#(
    parameter int NCHAN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gcfg_we,
    input  logic [GCFG_W-1:0] gcfg_wdata,
    input  logic [5:0]        word_idx,
    input  logic [NCHAN-1:0]  tc_raw,
    input  logic [NCHAN-1:0]  err_raw,
    input  logic [NCHAN-1:0]  tc_masked,
    input  logic [NCHAN-1:0]  err_masked,
    input  logic [NCHAN-1:0]  en_map,
    output logic [GCFG_W-1:0] gcfg,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst)          gcfg <= '0;
        else if (gcfg_we) gcfg <= gcfg_wdata;
    end

    always_comb begin
        case (word_idx)
            GW_STAT:    rdata = DATA_W'(tc_masked | err_masked);
            GW_TCSTAT:  rdata = DATA_W'(tc_masked);
            GW_ERRSTAT: rdata = DATA_W'(err_masked);
            GW_TCRAW:   rdata = DATA_W'(tc_raw);
            GW_ERRRAW:  rdata = DATA_W'(err_raw);
            GW_ENMAP:   rdata = DATA_W'(en_map);
            GW_GCFG:    rdata = DATA_W'(gcfg);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dmareg_pkg::*;
#(
    parameter int NCHAN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCHAN-1:0]  tc_set,
    input  logic [NCHAN-1:0]  err_set,
    output logic              irq_any,
    output logic              irq_err,
    output logic              irq_tc
);

    localparam logic TWO_CH = (NCHAN == 2);

    region_e           region;
    logic              wr_acc;
    logic [5:0]        word_idx;
    logic [DATA_W-1:0] chan_rdata, glob_rdata;
    logic [NCHAN-1:0]  en_map, tc_mask, err_mask;
    logic [NCHAN-1:0]  tc_raw, err_raw, tc_masked, err_masked;
    logic [GCFG_W-1:0] gcfg;
    chan_regs_t [NCHAN-1:0] regs;

    assign region   = decode_region(bus_addr);
    assign wr_acc   = bus_sel && bus_wr;
    assign word_idx = bus_addr[7:2];

    dma_chan_bank #(.NCHAN(NCHAN)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_acc && region == RGN_CHAN),
        .ch_idx   (bus_addr[7:5]),
        .reg_sel  (bus_addr[4:2]),
        .wdata    (bus_wdata),
        .rdata    (chan_rdata),
        .en_map   (en_map),
        .tc_mask  (tc_mask),
        .err_mask (err_mask),
        .regs     (regs)
    );

    dma_irq_ctrl #(.NCHAN(NCHAN)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .tc_set     (tc_set),
        .err_set    (err_set),
        .tc_clr_we  (wr_acc && region == RGN_GLOBAL && word_idx == GW_TCCLR),
        .err_clr_we (wr_acc && region == RGN_GLOBAL && word_idx == GW_ERRCLR),
        .clr_bits   (bus_wdata[NCHAN-1:0]),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .tc_raw     (tc_raw),
        .err_raw    (err_raw),
        .tc_masked  (tc_masked),
        .err_masked (err_masked),
        .irq_tc     (irq_tc),
        .irq_err    (irq_err),
        .irq_any    (irq_any)
    );

    dma_global_regs #(.NCHAN(NCHAN)) u_glob (
        .clk        (clk),
        .rst        (rst),
        .gcfg_we    (wr_acc && region == RGN_GLOBAL && word_idx == GW_GCFG),
        .gcfg_wdata (bus_wdata[GCFG_W-1:0]),
        .word_idx   (word_idx),
        .tc_raw     (tc_raw),
        .err_raw    (err_raw),
        .tc_masked  (tc_masked),
        .err_masked (err_masked),
        .en_map     (en_map),
        .gcfg       (gcfg),
        .rdata      (glob_rdata)
    );

    always_comb begin
        case (region)
            RGN_GLOBAL: bus_rdata = glob_rdata;
            RGN_CHAN:   bus_rdata = chan_rdata;
            RGN_ID:     bus_rdata = {24'h0, id_byte(bus_addr[4:2], TWO_CH)};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
    parameter int NCHAN = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [NCHAN-1:0] tc_set,
    input logic [NCHAN-1:0] err_set,
    input logic [NCHAN-1:0] tc_raw,
    input logic [NCHAN-1:0] err_raw,
    input logic [2:0]       gcfg,
    input logic             irq_tc,
    input logic             irq_err
);

    logic past_valid;
    always_ff @(posedge clk) begin
        if (rst) past_valid <= 1'b0;
        else     past_valid <= 1'b1;
    end

    assert_tc_set_R6: assert property (@(posedge clk) disable iff (rst)
        (tc_set != '0) |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));

    assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
        (err_set != '0) |=> ((err_raw & $past(err_set)) == $past(err_set)));

    assert_tc_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 12'h008)
        |=> ((tc_raw & $past(bus_wdata[NCHAN-1:0]) & ~$past(tc_set)) == '0));

    assert_err_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 12'h010)
        |=> ((err_raw & $past(bus_wdata[NCHAN-1:0]) & ~$past(err_set)) == '0));

    assert_tc_rise_R4: assert property (@(posedge clk) disable iff (rst)
        past_valid |-> ((tc_raw & ~$past(tc_raw) & ~$past(tc_set)) == '0));

    assert_err_rise_R4: assert property (@(posedge clk) disable iff (rst)
        past_valid |-> ((err_raw & ~$past(err_raw) & ~$past(err_set)) == '0));

    assert_irq_tc_R8: assert property (@(posedge clk) disable iff (rst)
        irq_tc |-> (tc_raw != '0));

    assert_irq_err_R8: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> (err_raw != '0));

    assert_reset_R12: assert property (@(posedge clk) disable iff (rst)
        !past_valid |-> (tc_raw == '0 && err_raw == '0 && gcfg == '0));

endmodule

bind dma_regfile dma_regfile_chk #(.NCHAN(NCHAN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tc_set    (tc_set),
    .err_set   (err_set),
    .tc_raw    (tc_raw),
    .err_raw   (err_raw),
    .gcfg      (gcfg),
    .irq_tc    (irq_tc),
    .irq_err   (irq_err)
);

// File: tb/sim_dma_regfile.sv
`timescale 1ns/1ps
module sim_dma_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [7:0]  tc_set = '0, err_set = '0;
    logic        irq_any, irq_err, irq_tc;
    logic        irq_any1, irq_err1, irq_tc1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    dma_regfile #(.NCHAN(8)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
        .tc_set(tc_set), .err_set(err_set),
        .irq_any(irq_any), .irq_err(irq_err), .irq_tc(irq_tc)
    );

    dma_regfile #(.NCHAN(2)) u1 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .tc_set(2'b00), .err_set(2'b00),
        .irq_any(irq_any1), .irq_err(irq_err1), .irq_tc(irq_tc1)
    );

    function automatic logic [11:0] ch_addr(input int c, input int r);
        return 12'(32'h100 + 32 * c + 4 * r);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d0,
                            output logic [31:0] d1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d0 = rdata0; d1 = rdata1;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] tcm, input logic [7:0] erm);
        @(negedge clk);
        tc_set = tcm; err_set = erm;
        @(negedge clk);
        tc_set = '0; err_set = '0;
    endtask

    task automatic t_reset_state();
        logic [31:0] a, b;
        bus_read(12'h030, a, b); check("R12", "gcfg after reset", a, 0);
        bus_read(ch_addr(0, 0), a, b); check("R12", "ch0 src after reset", a, 0);
        bus_read(12'h014, a, b); check("R12", "tc raw after reset", a, 0);
        check("R12", "irqs after reset", {irq_any, irq_err, irq_tc}, 0);
    endtask

    task automatic t_chan_regs();
        logic [31:0] a, b;
        for (int r = 0; r < 5; r++) begin
            bus_write(ch_addr(0, r), 32'hA000_0000 + r);
            bus_write(ch_addr(7, r), 32'h5700_0000 + r);
        end
        for (int r = 0; r < 5; r++) begin
            bus_read(ch_addr(0, r), a, b); check("R1", "ch0 readback", a, 32'hA000_0000 + r);
            bus_read(ch_addr(7, r), a, b); check("R1", "ch7 readback", a, 32'h5700_0000 + r);
        end
        bus_write(ch_addr(3, 5), 32'hDEAD_BEEF);
        bus_read(ch_addr(3, 5), a, b); check("R1", "slot 5 reads zero", a, 0);
        // clear ch0 cfg and ch7 cfg for later tests
        bus_write(ch_addr(0, 4), 0);
        bus_write(ch_addr(7, 4), 0);
    endtask

    task automatic t_out_of_range();
        logic [31:0] a, b;
        bus_write(ch_addr(3, 0), 32'h1234_5678);
        bus_read(ch_addr(3, 0), a, b);
        check("R2", "8-ch build stores ch3", a, 32'h1234_5678);
        check("R2", "2-ch build reads ch3 as zero", b, 0);
        bus_read(ch_addr(1, 0), a, b);
        check("R2", "2-ch build ch1 untouched", b, 0);
        bus_write(ch_addr(1, 1), 32'h0BAD_F00D);
        bus_read(ch_addr(1, 1), a, b);
        check("R2", "2-ch build ch1 stores", b, 32'h0BAD_F00D);
    endtask

    task automatic t_gcfg();
        logic [31:0] a, b;
        bus_write(12'h030, 32'hFFFF_FFFF);
        bus_read(12'h030, a, b); check("R3", "gcfg keeps bits 2:0", a, 32'h7);
        bus_write(12'h030, 32'h0000_0005);
        bus_read(12'h030, a, b); check("R3", "gcfg value 5", a, 32'h5);
    endtask

    task automatic t_raw_and_masks();
        logic [31:0] a, b;
        pulse(8'h05, 8'h82);
        bus_read(12'h014, a, b); check("R4", "tc raw", a, 32'h05);
        bus_read(12'h018, a, b); check("R4", "err raw", a, 32'h82);
        bus_read(12'h000, a, b); check("R7", "combined status unmasked", a, 0);
        check("R8", "irqs low with masks off", {irq_any, irq_err, irq_tc}, 0);
        bus_write(ch_addr(0, 4), 32'h0000_8000);
        bus_write(ch_addr(7, 4), 32'h0000_4000);
        bus_read(12'h004, a, b); check("R7", "masked tc", a, 32'h01);
        bus_read(12'h00C, a, b); check("R7", "masked err", a, 32'h80);
        bus_read(12'h000, a, b); check("R7", "combined status", a, 32'h81);
        check("R8", "irqs all high", {irq_any, irq_err, irq_tc}, 3'b111);
    endtask

    task automatic t_clear();
        logic [31:0] a, b;
        bus_write(12'h008, 32'h01);
        bus_read(12'h014, a, b); check("R5", "tc raw after clear", a, 32'h04);
        check("R8", "irq_tc low after clear", {irq_any, irq_err, irq_tc}, 3'b110);
        bus_write(12'h010, 32'h80);
        bus_read(12'h018, a, b); check("R5", "err raw after clear", a, 32'h02);
        check("R8", "irqs low after both clears", {irq_any, irq_err, irq_tc}, 3'b000);
    endtask

    task automatic t_set_wins();
        logic [31:0] a, b;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h0C;
        tc_set = 8'h08;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tc_set = '0;
        bus_read(12'h014, a, b); check("R6", "tc set beats clear", a, 32'h08);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h06;
        err_set = 8'h04;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; err_set = '0;
        bus_read(12'h018, a, b); check("R6", "err set beats clear", a, 32'h04);
    endtask

    task automatic t_enable_map();
        logic [31:0] a, b;
        bus_write(ch_addr(2, 4), 32'h0000_0001);
        bus_write(ch_addr(5, 4), 32'h0000_4001);
        bus_read(12'h01C, a, b); check("R9", "enabled map", a, 32'h24);
    endtask

    task automatic t_ident();
        logic [31:0] a, b;
        logic [7:0] exp8 [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            bus_read(12'(12'hFE0 + 4 * i), a, b);
            check("R10", "id byte", a, {24'h0, exp8[i]});
            if (i > 0) check("R10", "id byte 2-ch", b, {24'h0, exp8[i]});
        end
        bus_read(12'hFE0, a, b); check("R10", "2-ch first id byte", b, 32'h81);
    endtask

    task automatic t_undefined();
        logic [31:0] a, b;
        bus_read(12'h02C, a, b); check("R11", "index 11 reads zero", a, 0);
        bus_read(12'h200, a, b); check("R11", "0x200 reads zero", a, 0);
        bus_read(12'hF00, a, b); check("R11", "0xF00 reads zero", a, 0);
        bus_write(12'h200, 32'hFFFF_FFFF);
        bus_write(12'h040, 32'hFFFF_FFFF);
        bus_write(12'h014, 32'hFFFF_FFFF);
        bus_read(12'h030, a, b); check("R11", "gcfg unchanged", a, 32'h5);
        bus_read(12'h014, a, b); check("R11", "tc raw unchanged", a, 32'h08);
        bus_read(ch_addr(0, 0), a, b); check("R11", "ch0 src unchanged", a, 32'hA000_0000);
    endtask

    task automatic t_rereset();
        logic [31:0] a, b;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        bus_read(ch_addr(7, 3), a, b); check("R12", "ch7 ctrl cleared", a, 0);
        bus_read(12'h018, a, b); check("R12", "err raw cleared", a, 0);
        bus_read(12'h030, a, b); check("R12", "gcfg cleared", a, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_chan_regs();
        t_out_of_range();
        t_gcfg();
        t_raw_and_masks();
        t_clear();
        t_set_wins();
        t_enable_map();
        t_ident();
        t_undefined();
        t_rereset();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run hung, got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule